// File: doc/BRIEF.md
# Indexed Register Window Controller

This block lets a bus-side master reach three internal register banks through a single data window. A control register holds two bank-select bits, a 5-bit entry index and a fast-mode enable. The three banks are a 24-entry sequence configuration bank, a 24-entry per-channel averaging bank and a 25-entry conversion result bank. Every read or write of the window reaches the entry picked by the current index in the selected bank. After the access the index moves on by one, so software can stream a whole bank without rewriting the control register.

The result bank cannot be written from the window. It is filled through a separate deposit port driven by the converter. The fast-mode enable is held in the control register and passed to the converter as an output. Window reads have a latency of one cycle. The banks are written so that block RAM can be inferred.

Top module: `regwin_ctrl`

## Requirements
- R1: After a synchronous reset, the control register reads 0x0000, `fast_mode` is 0, the index is 0 and the result bank is selected.
- R2: The control register has these fields: index at bits 4:0, config-select at bit 5, average-select at bit 7 and fast-mode at bit 11. Bit 11 drives `fast_mode`. Every other bit always reads 0, whatever value is written (a write of 0xFFFF reads back as 0x08BF).
- R3: When config-select is 1, the window reaches the 24-entry sequence configuration bank for both reads and writes, whatever the value of average-select.
- R4: When config-select is 0 and average-select is 1, the window reaches the 24-entry averaging bank for both reads and writes.
- R5: When both select bits are 0, the window reads the 25-entry result bank and window writes are ignored. A pulse on `res_wr_en` stores `res_data` at entry `res_idx`. A deposit with `res_idx` of 25 or more is ignored.
- R6: A window read presents its data on `win_rdata` with `win_rvalid` high in the cycle after `win_rd_en`. `win_rvalid` is low in every other cycle.
- R7: Each cycle with `win_rd_en` or `win_wr_en` high is one access, including a cycle with both high, and it advances the index by exactly one. When both are high, the read returns the entry's old value and the write then stores the new one.
- R8: An access at an index equal to or above the last entry of the selected bank (23, 23 or 24) sets the index to 0.
- R9: A window read at an index beyond the selected bank returns 0. A window write at such an index changes no entry.
- R10: A control write sets the index and selects with no increment. If a window access falls in the same cycle, the access uses the old index and bank, and the written control value is what remains.
- R11: In a cycle with no window access and no control write, the control register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value |
| ctl_rdata | output | 16 | Control register contents |
| win_rd_en | input | 1 | Window read strobe |
| win_wr_en | input | 1 | Window write strobe |
| win_wdata | input | 16 | Window write data |
| win_rdata | output | 16 | Window read data, valid with `win_rvalid` |
| win_rvalid | output | 1 | Window read data valid, one cycle after the read |
| res_wr_en | input | 1 | Converter result deposit strobe |
| res_idx | input | 5 | Result entry to deposit into |
| res_data | input | 16 | Result value |
| fast_mode | output | 1 | Fast conversion mode enable to the converter |

## Verification
The hardest situations to reach are a window access and a control write landing in the same cycle, and a single cycle that both reads and writes the window. Neither happens in normal software-style traffic, so the bench drives both strobes together on purpose. It then reads the disturbed entries back through the window to confirm the old index and bank were used. Out-of-range indexes can only come from a control write, so the bench loads indexes 26 and 30 directly. It then re-reads the whole configuration bank to show that the stray write changed nothing.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  parameter int DATA_W = 16;
  parameter int IDX_W  = 5;
  parameter int SEQ_N  = 24;
  parameter int AVG_N  = 24;
  parameter int RES_N  = 25;

  typedef enum logic [1:0] {
    BK_RES = 2'd0,
    BK_AVG = 2'd1,
    BK_SEQ = 2'd2
  } bank_e;

  localparam int NUM_BANKS = 3;
  localparam int CFG_BIT   = 5;
  localparam int AVG_BIT   = 7;
  localparam int FAST_BIT  = 11;
endpackage

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int DW    = 16,
  parameter int IW    = 5,
  parameter int DEPTH = 24
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [IW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam logic [IW-1:0] LIMIT = IW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, read-first: suits block RAM inference
  always_ff @(posedge clk) begin
    if (wr_en && (wr_addr < LIMIT))
      mem[wr_addr] <= wr_data;
    if (rd_en)
      rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl
  import regwin_pkg::*;
#(
  parameter int IW    = 5,
  parameter int SEQ_D = 24,
  parameter int AVG_D = 24,
  parameter int RES_D = 25
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr_en,
  input  logic [15:0]   ctl_wdata,
  input  logic          acc,
  output logic [IW-1:0] idx,
  output bank_e         bank,
  output logic          in_range,
  output logic          fast,
  output logic [15:0]   ctl_rdata
);
  localparam logic [IW-1:0] SEQ_LAST = IW'(SEQ_D - 1);
  localparam logic [IW-1:0] AVG_LAST = IW'(AVG_D - 1);
  localparam logic [IW-1:0] RES_LAST = IW'(RES_D - 1);

  logic [IW-1:0] idx_q;
  logic          cfg_q, avg_q, fast_q;
  logic [IW-1:0] last;

  always_comb begin
    if (cfg_q) begin
      bank = BK_SEQ;
      last = SEQ_LAST;
    end else if (avg_q) begin
      bank = BK_AVG;
      last = AVG_LAST;
    end else begin
      bank = BK_RES;
      last = RES_LAST;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      cfg_q  <= 1'b0;
      avg_q  <= 1'b0;
      fast_q <= 1'b0;
    end else if (ctl_wr_en) begin
      idx_q  <= ctl_wdata[IW-1:0];
      cfg_q  <= ctl_wdata[CFG_BIT];
      avg_q  <= ctl_wdata[AVG_BIT];
      fast_q <= ctl_wdata[FAST_BIT];
    end else if (acc) begin
      idx_q  <= (idx_q >= last) ? '0 : idx_q + 1'b1;
    end
  end

  assign idx      = idx_q;
  assign in_range = (idx_q <= last);
  assign fast     = fast_q;

  always_comb begin
    ctl_rdata           = '0;
    ctl_rdata[IW-1:0]   = idx_q;
    ctl_rdata[CFG_BIT]  = cfg_q;
    ctl_rdata[AVG_BIT]  = avg_q;
    ctl_rdata[FAST_BIT] = fast_q;
  end

  assert_idx_step_R7: assert property (@(posedge clk) disable iff (rst)
    (acc && !ctl_wr_en && idx_q < last) |=> idx_q == $past(idx_q) + 1'b1);

  assert_idx_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (acc && !ctl_wr_en && idx_q >= last) |=> idx_q == '0);

  assert_ctl_load_R10: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_en |=> ctl_rdata == ($past(ctl_wdata) & 16'h08BF));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!acc && !ctl_wr_en) |=> $stable(ctl_rdata));
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
  import regwin_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int IW    = IDX_W,
  parameter int SEQ_D = SEQ_N,
  parameter int AVG_D = AVG_N,
  parameter int RES_D = RES_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_wr_en,
  input  logic [15:0]   ctl_wdata,
  output logic [15:0]   ctl_rdata,
  input  logic          win_rd_en,
  input  logic          win_wr_en,
  input  logic [DW-1:0] win_wdata,
  output logic [DW-1:0] win_rdata,
  output logic          win_rvalid,
  input  logic          res_wr_en,
  input  logic [IW-1:0] res_idx,
  input  logic [DW-1:0] res_data,
  output logic          fast_mode
);
  logic [IW-1:0] idx;
  bank_e         bank;
  logic          in_range;
  logic          acc;
  logic [DW-1:0] rd_data_v [NUM_BANKS];

  assign acc = win_rd_en | win_wr_en;

  regwin_ctl #(.IW(IW), .SEQ_D(SEQ_D), .AVG_D(AVG_D), .RES_D(RES_D)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr_en (ctl_wr_en),
    .ctl_wdata (ctl_wdata),
    .acc       (acc),
    .idx       (idx),
    .bank      (bank),
    .in_range  (in_range),
    .fast      (fast_mode),
    .ctl_rdata (ctl_rdata)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam int DEPTH = (g == int'(BK_SEQ)) ? SEQ_D :
                           (g == int'(BK_AVG)) ? AVG_D : RES_D;
    logic          we;
    logic [IW-1:0] wa;
    logic [DW-1:0] wd;
    logic          hit;

    assign hit = (bank == bank_e'(g)) && in_range;

    if (g == int'(BK_RES)) begin : g_res
      assign we = res_wr_en;
      assign wa = res_idx;
      assign wd = res_data;
    end else begin : g_cfg
      assign we = win_wr_en && hit;
      assign wa = idx;
      assign wd = win_wdata;
    end

    regwin_bank #(.DW(DW), .IW(IW), .DEPTH(DEPTH)) u_bank (
      .clk     (clk),
      .wr_en   (we),
      .wr_addr (wa),
      .wr_data (wd),
      .rd_en   (win_rd_en && hit),
      .rd_addr (idx),
      .rd_data (rd_data_v[g])
    );
  end

  bank_e rsel_q;
  logic  rok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_rvalid <= 1'b0;
      rsel_q     <= BK_RES;
      rok_q      <= 1'b0;
    end else begin
      win_rvalid <= win_rd_en;
      if (win_rd_en) begin
        rsel_q <= bank;
        rok_q  <= in_range;
      end
    end
  end

  assign win_rdata = rok_q ? rd_data_v[rsel_q] : '0;

  assert_rvalid_follows_R6: assert property (@(posedge clk) disable iff (rst)
    win_rd_en |=> win_rvalid);

  assert_rvalid_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !win_rd_en |=> !win_rvalid);

  assert_oor_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (win_rd_en && !in_range) |=> win_rdata == '0);

  always @(posedge clk) begin
    if (!rst && $past(rst))
      assert_reset_state_R1: assert (ctl_rdata == 16'h0000 && !fast_mode);
  end
endmodule

// File: tb/regwin_ctrl_test.sv
module regwin_ctrl_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_wr_en = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        win_rd_en = 1'b0;
  logic        win_wr_en = 1'b0;
  logic [15:0] win_wdata = '0;
  logic [15:0] win_rdata;
  logic        win_rvalid;
  logic        res_wr_en = 1'b0;
  logic [4:0]  res_idx = '0;
  logic [15:0] res_data = '0;
  logic        fast_mode;

  always #4 clk = ~clk;

  regwin_ctrl uut (
    .clk(clk), .rst(rst),
    .ctl_wr_en(ctl_wr_en), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .win_rd_en(win_rd_en), .win_wr_en(win_wr_en), .win_wdata(win_wdata),
    .win_rdata(win_rdata), .win_rvalid(win_rvalid),
    .res_wr_en(res_wr_en), .res_idx(res_idx), .res_data(res_data),
    .fast_mode(fast_mode)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [15:0] exp_q [$];
  string       tag_q [$];

  logic [15:0] seq_m [24];
  logic [15:0] avg_m [24];
  logic [15:0] res_m [25];
  logic [15:0] ctl_m = '0;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: every valid read must match the oldest expected item
  always @(negedge clk) begin
    if (!rst && win_rvalid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R6: actual unexpected rvalid expected no read data");
      end else begin
        check(tag_q.pop_front(), win_rdata, exp_q.pop_front());
      end
    end
  end

  function automatic int model_depth();
    if (ctl_m[5]) return 24;
    if (ctl_m[7]) return 24;
    return 25;
  endfunction

  // one cycle of stimulus; model follows the requirements
  task automatic cycle(bit rd, bit wr, logic [15:0] d, bit cw, logic [15:0] cv, string tag);
    int i = int'(ctl_m[4:0]);
    bit inr = i < model_depth();
    logic [15:0] e = '0;
    if (rd && inr) begin
      if (ctl_m[5])      e = seq_m[i];
      else if (ctl_m[7]) e = avg_m[i];
      else               e = res_m[i];
    end
    if (rd) begin
      exp_q.push_back(e);
      tag_q.push_back(tag);
    end
    win_rd_en = rd; win_wr_en = wr; win_wdata = d;
    ctl_wr_en = cw; ctl_wdata = cv;
    @(negedge clk);
    win_rd_en = 0; win_wr_en = 0; ctl_wr_en = 0;
    if (wr && inr) begin
      if (ctl_m[5])      seq_m[i] = d;
      else if (ctl_m[7]) avg_m[i] = d;
    end
    if (cw) ctl_m = cv & 16'h08BF;
    else if (rd || wr) ctl_m[4:0] = (i >= model_depth() - 1) ? 5'd0 : 5'(i + 1);
  endtask

  task automatic set_ctl(logic [15:0] v);
    cycle(0, 0, '0, 1, v, "R10");
  endtask

  task automatic deposit(int i, logic [15:0] d);
    res_wr_en = 1; res_idx = 5'(i); res_data = d;
    @(negedge clk);
    res_wr_en = 0;
    if (i < 25) res_m[i] = d;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1 ctl after reset", ctl_rdata, 16'h0000);
    check("R1 fast_mode after reset", {15'd0, fast_mode}, 16'd0);

    // R2 field mask and fast-mode pin
    set_ctl(16'hFFFF);
    check("R2 reserved bits read 0", ctl_rdata, 16'h08BF);
    check("R2 fast_mode pin", {15'd0, fast_mode}, 16'd1);
    set_ctl(16'h0000);
    check("R2 cleared", ctl_rdata, 16'h0000);

    // R5 converter deposits, including an out-of-range one
    for (int k = 0; k < 25; k++) deposit(k, 16'hA000 + 16'(k * 3));
    deposit(27, 16'hBAD0);

    // R3 sequence bank: fill, wrap, read back
    set_ctl(16'h0020);
    for (int k = 0; k < 24; k++) cycle(0, 1, 16'h5100 + 16'(k), 0, '0, "R3");
    check("R8 seq wrap after 24 writes", ctl_rdata, 16'h0020);
    for (int k = 0; k < 24; k++) cycle(1, 0, '0, 0, '0, "R3 seq read");
    check("R7 seq index after reads", ctl_rdata, ctl_m);

    // R4 averaging bank
    set_ctl(16'h0080);
    for (int k = 0; k < 24; k++) cycle(0, 1, 16'h7700 ^ 16'(k * 5), 0, '0, "R4");
    for (int k = 0; k < 24; k++) cycle(1, 0, '0, 0, '0, "R4 avg read");
    check("R8 avg wrap", ctl_rdata, 16'h0080);

    // R3 both selects set reach the sequence bank
    set_ctl(16'h00A4);
    for (int k = 0; k < 4; k++) cycle(1, 0, '0, 0, '0, "R3 both selects");

    // R5 result bank: read all, wrap at 25, ignored write
    set_ctl(16'h0000);
    for (int k = 0; k < 25; k++) cycle(1, 0, '0, 0, '0, "R5 result read");
    check("R8 result wrap after 25", ctl_rdata, 16'h0000);
    set_ctl(16'h0003);
    cycle(0, 1, 16'hDEAD, 0, '0, "R5");
    check("R7 index after ignored write", ctl_rdata, 16'h0004);
    set_ctl(16'h0003);
    cycle(1, 0, '0, 0, '0, "R5 result write ignored");

    // R9 out-of-range read and write
    set_ctl(16'h003E);
    cycle(1, 0, '0, 0, '0, "R9 oor read");
    check("R8 oor index to 0", ctl_rdata, 16'h0020);
    set_ctl(16'h003A);
    cycle(0, 1, 16'hFACE, 0, '0, "R9");
    set_ctl(16'h0020);
    for (int k = 0; k < 24; k++) cycle(1, 0, '0, 0, '0, "R9 seq unchanged");

    // R10 control write coinciding with a window write
    set_ctl(16'h0022);
    cycle(0, 1, 16'h0C0C, 1, 16'h0085, "R10");
    check("R10 ctl value wins", ctl_rdata, 16'h0085);
    set_ctl(16'h0022);
    cycle(1, 0, '0, 0, '0, "R10 access used old index");

    // R7 read and write in one cycle
    set_ctl(16'h0083);
    cycle(1, 1, 16'h1234, 0, '0, "R7 rd+wr old data");
    check("R7 single step", ctl_rdata, 16'h0084);
    set_ctl(16'h0083);
    cycle(1, 0, '0, 0, '0, "R7 rd+wr new data");

    // R11 idle hold, and no stray rvalid (monitor)
    repeat (6) @(negedge clk);
    check("R11 idle hold", ctl_rdata, ctl_m);
    check("R6 rvalid low when idle", {15'd0, win_rvalid}, 16'd0);
    check("R6 all reads returned", 16'(exp_q.size()), 16'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule